// File: doc/BRIEF.md
# Indirect Memory Window

This block gives a host a two-register window into a local word memory. The host first writes a control word that holds a block number, a word offset inside that block, and two separate auto-advance enables: one for writes and one for reads. It then moves 32-bit words through a single data register. After each data access whose direction has its advance enabled, the hardware steps the word pointer by one. A whole buffer can therefore be streamed in or out with one control write followed by back-to-back data accesses.

The host side is a plain register strobe interface with no valid/ready handshake and no back-pressure. Every strobe is taken in the cycle in which it is sampled. A data read returns the addressed word combinationally in that same cycle. Pointer updates take effect on the next rising clock edge. Each block holds 64 words. The block field is 8 bits wide, and the physical memory holds `MEM_BLOCKS` blocks, selected by the low bits of the block field. The host packs bytes little-endian, with the lowest-addressed byte in bits 7:0. The window sees only whole words.

Top module: `iwin_port`

## Requirements
- R1: After reset the block field, the offset field and both advance enables are zero, so a control read returns 0x0000_0000.
- R2: A write to the control register at `BASE_ADDR` (default 0xAC0) loads the word offset from bits 7:2, the block from bits 15:8, the write-advance enable from bit 24 and the read-advance enable from bit 25. A control read returns the current values in those positions, and bits 1:0, 23:16 and 31:26 read as zero.
- R3: A write to the data register at `BASE_ADDR+4` stores the 32-bit word at the current block/offset. When bit 24 is set, the pointer then advances by one word on that clock edge.
- R4: A read of the data register returns the word at the current block/offset in the same cycle as the read strobe. When bit 25 is set, the pointer advances by one word on the following edge.
- R5: A data access whose direction has its advance bit clear leaves the pointer unchanged. With neither bit set, repeated accesses all hit the same word.
- R6: Advancing past offset 63 wraps the offset to 0 and adds one to the block, so a burst crosses block boundaries.
- R7: The block field wraps from 255 to 0. The memory bank is chosen by the low log2(`MEM_BLOCKS`) bits of the block, so block 255 aliases block 3 when `MEM_BLOCKS` is 4.
- R8: When a data read and a data write arrive in the same cycle, the read returns the old word, the write lands at the pre-advance address, and the pointer advances by at most one word.
- R9: Reads of any other address return zero, and writes to any other address change neither the pointer nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W (12) | Byte address of the access |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid in the strobe cycle |

## Verification
The bench targets offset-to-block carry and the 255-to-0 block wrap. A design that dropped the carry would rewrite block 1 instead of moving on to block 2. It also checks aliasing of high block numbers onto the smaller physical memory. A simultaneous data read and write must return the old word and store to the pre-advance address; a design that advanced first would read or write one word too far. Separate enables are tested by reading with only the write enable set, and writing with only the read enable set; a design that shared the enables would move the pointer in both cases. The bench also checks that address bits 1:0 and unused control bits read back as zero.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  localparam int WORD_W    = 32;
  localparam int OFS_W     = 6;
  localparam int BLK_W     = 8;
  localparam int PTR_W     = OFS_W + BLK_W;
  localparam int OFS_LSB   = 2;
  localparam int BLK_LSB   = OFS_LSB + OFS_W;
  localparam int INC_W_BIT = 24;
  localparam int INC_R_BIT = 25;

  typedef struct packed {
    logic             inc_r;
    logic             inc_w;
    logic [BLK_W-1:0] blk;
    logic [OFS_W-1:0] ofs;
  } win_ctrl_t;

  function automatic logic [WORD_W-1:0] ctrl_pack(win_ctrl_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[OFS_LSB +: OFS_W] = c.ofs;
    w[BLK_LSB +: BLK_W] = c.blk;
    w[INC_W_BIT]        = c.inc_w;
    w[INC_R_BIT]        = c.inc_r;
    return w;
  endfunction
endpackage

// File: rtl/iwin_decode.sv
module iwin_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'hAC0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              ctrl_wr,
  output logic              ctrl_rd,
  output logic              data_wr,
  output logic              data_rd
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(4);

  logic hit_ctrl, hit_data;

  always_comb begin
    hit_ctrl = (addr == BASE_ADDR);
    hit_data = (addr == DATA_ADDR);
    ctrl_wr  = wr & hit_ctrl;
    ctrl_rd  = rd & hit_ctrl;
    data_wr  = wr & hit_data;
    data_rd  = rd & hit_data;
  end
endmodule

// File: rtl/iwin_ptr.sv
module iwin_ptr
  import iwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  win_ctrl_t        load_val,
  input  logic             data_wr,
  input  logic             data_rd,
  output win_ctrl_t        cur,
  output logic [PTR_W-1:0] ptr
);
  win_ctrl_t        state_q;
  logic             advance;
  logic [PTR_W-1:0] ptr_next;

  always_comb begin
    ptr      = {state_q.blk, state_q.ofs};
    advance  = (data_wr & state_q.inc_w) | (data_rd & state_q.inc_r);
    ptr_next = ptr + PTR_W'(1);
    cur      = state_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (load) begin
      state_q <= load_val;
    end else if (advance) begin
      {state_q.blk, state_q.ofs} <= ptr_next;
    end
  end
endmodule

// File: rtl/iwin_ram.sv
module iwin_ram
  import iwin_pkg::*;
#(
  parameter int MEM_BLOCKS = 4,
  localparam int SEL_W = $clog2(MEM_BLOCKS),
  localparam int WORDS = 1 << OFS_W
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [SEL_W+OFS_W-1:0] addr,
  input  logic [WORD_W-1:0]      wdata,
  output logic [WORD_W-1:0]      rdata
);
  logic [SEL_W-1:0]  sel;
  logic [OFS_W-1:0]  word;
  logic [WORD_W-1:0] bank_q [MEM_BLOCKS];

  assign sel  = addr[OFS_W +: SEL_W];
  assign word = addr[OFS_W-1:0];

  for (genvar b = 0; b < MEM_BLOCKS; b++) begin : g_bank
    logic [WORD_W-1:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (we && sel == SEL_W'(b)) mem[word] <= wdata;
    end
    assign bank_q[b] = mem[word];
  end

  assign rdata = bank_q[sel];
endmodule

// File: rtl/iwin_port.sv
module iwin_port
  import iwin_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'hAC0,
  parameter int MEM_BLOCKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata
);
  localparam int SEL_W = $clog2(MEM_BLOCKS);

  logic             ctrl_wr, ctrl_rd, data_wr, data_rd;
  win_ctrl_t        load_val, cur_ctrl;
  logic [PTR_W-1:0] word_ptr;
  logic [WORD_W-1:0] ram_q;
  logic             unused_wbits;

  iwin_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(host_addr), .wr(host_wr), .rd(host_rd),
    .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
    .data_wr(data_wr), .data_rd(data_rd)
  );

  always_comb begin
    load_val.ofs   = host_wdata[OFS_LSB +: OFS_W];
    load_val.blk   = host_wdata[BLK_LSB +: BLK_W];
    load_val.inc_w = host_wdata[INC_W_BIT];
    load_val.inc_r = host_wdata[INC_R_BIT];
  end
  assign unused_wbits = ^{host_wdata[OFS_LSB-1:0], host_wdata[INC_W_BIT-1:BLK_LSB+BLK_W],
                          host_wdata[WORD_W-1:INC_R_BIT+1]};

  iwin_ptr u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(ctrl_wr), .load_val(load_val),
    .data_wr(data_wr), .data_rd(data_rd),
    .cur(cur_ctrl), .ptr(word_ptr)
  );

  iwin_ram #(.MEM_BLOCKS(MEM_BLOCKS)) u_ram (
    .clk(clk), .we(data_wr),
    .addr(word_ptr[SEL_W+OFS_W-1:0]),
    .wdata(host_wdata), .rdata(ram_q)
  );

  always_comb begin
    if (ctrl_rd)      host_rdata = ctrl_pack(cur_ctrl);
    else if (data_rd) host_rdata = ram_q;
    else              host_rdata = '0;
  end
endmodule

// File: rtl/iwin_port_chk.sv
module iwin_port_chk
  import iwin_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'hAC0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [WORD_W-1:0] host_wdata,
  input logic [WORD_W-1:0] host_rdata,
  input logic [PTR_W-1:0]  ptr,
  input logic              inc_w,
  input logic              inc_r
);
  logic at_ctrl, at_data, at_none;
  logic unused_bits;
  assign at_ctrl = host_addr == BASE_ADDR;
  assign at_data = host_addr == BASE_ADDR + ADDR_W'(4);
  assign at_none = !at_ctrl && !at_data;
  assign unused_bits = ^{host_wdata[1:0], host_wdata[31:16]};

  // R2
  ctrl_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && at_ctrl) |-> (host_rdata[1:0] == 2'b0 && host_rdata[23:16] == 8'h0
                              && host_rdata[31:26] == 6'h0));
  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && at_ctrl) |=> (ptr == {$past(host_wdata[15:8]), $past(host_wdata[7:2])}));
  // R3
  wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && at_data && inc_w) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));
  // R4
  rd_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && at_data && inc_r && !(host_wr && at_ctrl)) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_data && (host_wr || host_rd) && !(host_wr && inc_w) && !(host_rd && inc_r))
      |=> $stable(ptr));
  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && at_none) |-> (host_rdata == '0));
  // R9
  unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_none && (host_wr || host_rd)) |=> $stable(ptr));
endmodule

bind iwin_port iwin_port_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .ptr(word_ptr), .inc_w(cur_ctrl.inc_w), .inc_r(cur_ctrl.inc_r)
);

// File: tb/iwin_port_bench.sv
`timescale 1ns/1ps
module iwin_port_bench;
  localparam logic [11:0] CTRL = 12'hAC0;
  localparam logic [11:0] DATA = 12'hAC4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] host_addr = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iwin_port u_iwin_port (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  task automatic bus_rw(logic [11:0] a, logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    host_addr = a; host_wdata = wd; host_wr = 1'b1; host_rd = 1'b1;
    #1 rd = host_rdata;
    @(posedge clk); #1 begin host_wr = 1'b0; host_rd = 1'b0; end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_rd(CTRL, v); check("R1 reset control", v, 32'h0);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] v;
    bus_wr(CTRL, 32'hFFFF_FFFF);
    bus_rd(CTRL, v); check("R2 control readback", v, 32'h0300_FFFC);
  endtask

  task automatic t_bursts();
    logic [31:0] v;
    bus_wr(CTRL, 32'h0100_0200);
    for (int i = 0; i < 4; i++) bus_wr(DATA, 32'hA000_0000 + i);
    bus_rd(CTRL, v); check("R3 write advance", v, 32'h0100_0210);
    bus_wr(CTRL, 32'h0200_0200);
    for (int i = 0; i < 4; i++) begin
      bus_rd(DATA, v); check("R4 read burst data", v, 32'hA000_0000 + i);
    end
    bus_rd(CTRL, v); check("R4 read advance", v, 32'h0200_0210);
  endtask

  task automatic t_no_inc();
    logic [31:0] v;
    bus_wr(CTRL, 32'h0000_0105);
    bus_rd(CTRL, v); check("R2 low bits dropped", v, 32'h0000_0104);
    bus_wr(DATA, 32'h1111_1111);
    bus_wr(DATA, 32'h2222_2222);
    bus_rd(DATA, v); check("R5 same word", v, 32'h2222_2222);
    bus_rd(DATA, v); check("R5 same word again", v, 32'h2222_2222);
    bus_rd(CTRL, v); check("R5 pointer held", v, 32'h0000_0104);
    bus_wr(CTRL, 32'h0100_0104);
    bus_rd(DATA, v); bus_rd(DATA, v);
    bus_rd(CTRL, v); check("R5 reads ignore write enable", v, 32'h0100_0104);
    bus_wr(CTRL, 32'h0200_0104);
    bus_wr(DATA, 32'h3333_3333);
    bus_rd(CTRL, v); check("R5 writes ignore read enable", v, 32'h0200_0104);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    bus_wr(CTRL, 32'h0100_01FC);
    bus_wr(DATA, 32'hB0B0_0000);
    bus_wr(DATA, 32'hB0B0_0001);
    bus_rd(CTRL, v); check("R6 carry into block", v, 32'h0100_0204);
    bus_wr(CTRL, 32'h0000_01FC);
    bus_rd(DATA, v); check("R6 last word of block", v, 32'hB0B0_0000);
    bus_wr(CTRL, 32'h0000_0200);
    bus_rd(DATA, v); check("R6 first word of next block", v, 32'hB0B0_0001);
    bus_wr(CTRL, 32'h0100_FFFC);
    bus_wr(DATA, 32'hC0DE_00FF);
    bus_rd(CTRL, v); check("R7 block wraps to 0", v, 32'h0100_0000);
    bus_wr(CTRL, 32'h0000_03FC);
    bus_rd(DATA, v); check("R7 block alias", v, 32'hC0DE_00FF);
  endtask

  task automatic t_rw_same();
    logic [31:0] v;
    bus_wr(CTRL, 32'h0000_0000);
    bus_wr(DATA, 32'h5555_0000);
    bus_wr(CTRL, 32'h0300_0000);
    bus_rw(DATA, 32'h6666_0000, v); check("R8 read sees old word", v, 32'h5555_0000);
    bus_rd(CTRL, v); check("R8 single advance", v, 32'h0300_0004);
    bus_wr(CTRL, 32'h0000_0000);
    bus_rd(DATA, v); check("R8 write at old address", v, 32'h6666_0000);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_wr(CTRL, 32'h0100_0108);
    bus_wr(12'h000, 32'hFFFF_FFFF);
    bus_wr(12'hAC8, 32'hFFFF_FFFF);
    bus_rd(12'hAC8, v); check("R9 unmapped read zero", v, 32'h0);
    bus_rd(CTRL, v); check("R9 control untouched", v, 32'h0100_0108);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_ctrl_fields();
    t_bursts();
    t_no_inc();
    t_wrap();
    t_rw_same();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule